// File: doc/BRIEF.md
# Sum of Absolute Differences Engine

The block compares two equal-length arrays of unsigned 8-bit samples and reports how far apart they are as one number: the sum, over every index, of the absolute difference between the two samples at that index. Both arrays live in external read-only memories with a combinational read path. The two memories share one address and one read enable, and each returns its sample on its own data input in the same cycle.

A run begins when `go_i` is seen high while the controller is idle. The controller clears its running sum and its index and then alternates between a loop-test cycle and an accumulate cycle for each element. It spends two cycles per element, so the default 256-element arrays take 512 cycles of loop work. Once the index reaches the array length, the total is copied into the `sad_o` output register. That register keeps the value until the next run completes. A system would use the result to decide whether two frames are similar enough to send only their difference.

Top module: `sad_engine`

## Requirements
- R1: While `rst_ni` is low and after its release, `sad_o` is 0 and `rd_en_o` is 0 until a run is started.
- R2: Counting the clock edge that samples `go_i` high in idle as edge 1, `rd_en_o` is high after edges 3, 5, 7, ... 513 (256 single-cycle pulses, each followed by one low cycle) and is low after every other edge of the run.
- R3: During the k-th `rd_en_o` pulse (k counted from 0), `addr_o` equals k, so addresses 0 to 255 are visited once each in ascending order.
- R4: The completed result equals the sum over all indices of |A[i] - B[i]|, with both samples treated as unsigned 8-bit values and each difference zero-extended to 32 bits before the add.
- R5: `sad_o` takes the new result after edge 516 of the run and still shows the previous result after edge 515.
- R6: After a run, `sad_o` keeps its value for as long as the controller stays idle with `go_i` low.
- R7: A high `go_i` during a run does not restart it or change its timing or its result.
- R8: The index is one bit wider than the address range needs, so completion is seen when it reaches 256; `sad_o` changes only while `addr_o` reads 256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| go_i | input | 1 | Starts a run when seen in idle |
| addr_o | output | 9 | Shared element address for both memories |
| rd_en_o | output | 1 | Shared read enable, high in accumulate cycles |
| a_data_i | input | 8 | Sample from array A at `addr_o` |
| b_data_i | input | 8 | Sample from array B at `addr_o` |
| sad_o | output | 32 | Registered sum of absolute differences |

## Verification
The assertions assume that the memories answer within the same cycle with a sample for any address below 256, and that `go_i` is a level input that the bench may raise at any point. They do not assume it arrives only in idle. The stimulus pulses `go_i` for one cycle to start a run and raises it again in the middle of one run. The arrays are filled with seeded random bytes and with all-equal, all-maximum-A and all-maximum-B patterns, so the unsigned difference is exercised in both directions and the sum reaches its largest value, 65280.

// File: rtl/sad_pkg.sv
package sad_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_TEST,
    ST_ACC,
    ST_DONE
  } sad_state_e;
endpackage

// File: rtl/sad_absdiff.sv
module sad_absdiff #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] diff_o
);
  // larger minus smaller keeps the result unsigned
  always_comb begin
    if (a_i >= b_i) diff_o = a_i - b_i;
    else            diff_o = b_i - a_i;
  end
endmodule

// File: rtl/sad_ctrl.sv
module sad_ctrl
  import sad_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic idx_done_i,
  output logic clr_o,
  output logic acc_o,
  output logic load_o
);
  sad_state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (go_i) state_d = ST_INIT;
      ST_INIT: state_d = ST_TEST;
      ST_TEST: state_d = idx_done_i ? ST_DONE : ST_ACC;
      ST_ACC:  state_d = ST_TEST;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign clr_o  = (state_q == ST_INIT);
  assign acc_o  = (state_q == ST_ACC);
  assign load_o = (state_q == ST_DONE);
endmodule

// File: rtl/sad_datapath.sv
module sad_datapath #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 256,
  parameter int SUM_W  = 32,
  parameter int IDX_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              acc_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] a_data_i,
  input  logic [DATA_W-1:0] b_data_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              idx_done_o,
  output logic [SUM_W-1:0]  sad_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH);

  logic [IDX_W-1:0]  idx_q;
  logic [SUM_W-1:0]  sum_q, sad_q;
  logic [DATA_W-1:0] diff;

  sad_absdiff #(.DATA_W(DATA_W)) absdiff_i (
    .a_i    (a_data_i),
    .b_i    (b_data_i),
    .diff_o (diff)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      sum_q <= '0;
    end else if (clr_i) begin
      idx_q <= '0;
      sum_q <= '0;
    end else if (acc_i) begin
      idx_q <= idx_q + 1'b1;
      sum_q <= sum_q + SUM_W'(diff);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sad_q <= '0;
    else if (load_i) sad_q <= sum_q;
  end

  assign idx_o      = idx_q;
  assign idx_done_o = (idx_q >= LAST_IDX);
  assign sad_o      = sad_q;
endmodule

// File: rtl/sad_engine.sv
module sad_engine #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 256,
  parameter int SUM_W  = 32,
  parameter int IDX_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  output logic [IDX_W-1:0]  addr_o,
  output logic              rd_en_o,
  input  logic [DATA_W-1:0] a_data_i,
  input  logic [DATA_W-1:0] b_data_i,
  output logic [SUM_W-1:0]  sad_o
);
  logic clr, acc, load, idx_done;

  sad_ctrl ctrl_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (go_i),
    .idx_done_i (idx_done),
    .clr_o      (clr),
    .acc_o      (acc),
    .load_o     (load)
  );

  sad_datapath #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .SUM_W  (SUM_W),
    .IDX_W  (IDX_W)
  ) dp_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .acc_i      (acc),
    .load_i     (load),
    .a_data_i   (a_data_i),
    .b_data_i   (b_data_i),
    .idx_o      (addr_o),
    .idx_done_o (idx_done),
    .sad_o      (sad_o)
  );

  assign rd_en_o = acc;
endmodule

// File: rtl/sad_engine_chk.sv
module sad_engine_chk #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 256,
  parameter int SUM_W  = 32,
  parameter int IDX_W  = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [IDX_W-1:0] addr_o,
  input logic             rd_en_o,
  input logic [SUM_W-1:0] sad_o
);
  localparam longint MAX_SUM = longint'(DEPTH) * ((longint'(1) << DATA_W) - 1);

  assert_rd_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |=> !rd_en_o);

  assert_addr_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> (addr_o < IDX_W'(DEPTH)));

  assert_addr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_o && $past(rd_en_o, 2)) |-> (addr_o == $past(addr_o, 2) + IDX_W'(1)));

  assert_sum_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sad_o <= SUM_W'(MAX_SUM));

  assert_sad_change_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sad_o) |-> (addr_o == IDX_W'(DEPTH)));
endmodule

bind sad_engine sad_engine_chk #(
  .DATA_W (DATA_W),
  .DEPTH  (DEPTH),
  .SUM_W  (SUM_W),
  .IDX_W  (IDX_W)
) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_o  (addr_o),
  .rd_en_o (rd_en_o),
  .sad_o   (sad_o)
);

// File: tb/sad_engine_tb_top.sv
`timescale 1ns/1ps
module sad_engine_tb_top;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 256;
  localparam int SUM_W  = 32;
  localparam int IDX_W  = 9;
  localparam int LAST_EDGE = 2 * DEPTH + 4;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              go_i = 1'b0;
  logic [IDX_W-1:0]  addr_o;
  logic              rd_en_o;
  logic [DATA_W-1:0] a_data_i, b_data_i;
  logic [SUM_W-1:0]  sad_o;

  logic [DATA_W-1:0] mem_a [DEPTH];
  logic [DATA_W-1:0] mem_b [DEPTH];

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk_i = ~clk_i;

  sad_engine dut_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .go_i     (go_i),
    .addr_o   (addr_o),
    .rd_en_o  (rd_en_o),
    .a_data_i (a_data_i),
    .b_data_i (b_data_i),
    .sad_o    (sad_o)
  );

  always_comb begin
    if (addr_o < IDX_W'(DEPTH)) begin
      a_data_i = mem_a[addr_o[7:0]];
      b_data_i = mem_b[addr_o[7:0]];
    end else begin
      a_data_i = '0;
      b_data_i = '0;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint ref_sad();
    longint s = 0;
    for (int i = 0; i < DEPTH; i++)
      s += (mem_a[i] >= mem_b[i]) ? longint'(mem_a[i] - mem_b[i])
                                  : longint'(mem_b[i] - mem_a[i]);
    return s;
  endfunction

  // mode: 0 random, 1 equal, 2 A max, 3 B max
  task automatic fill(input int mode);
    for (int i = 0; i < DEPTH; i++) begin
      case (mode)
        1: begin mem_a[i] = 8'(i * 7); mem_b[i] = 8'(i * 7); end
        2: begin mem_a[i] = 8'hFF; mem_b[i] = 8'h00; end
        3: begin mem_a[i] = 8'h00; mem_b[i] = 8'hFF; end
        default: begin mem_a[i] = 8'($urandom); mem_b[i] = 8'($urandom); end
      endcase
    end
  endtask

  task automatic run(input string name, input bit poke_go);
    longint exp_sad = ref_sad();
    longint old_sad = longint'(sad_o);
    int rd_bad = 0, addr_bad = 0, pulses = 0;
    @(negedge clk_i) go_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i) go_i = 1'b0;
    for (int n = 2; n <= LAST_EDGE; n++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      begin
        bit exp_rd = (n >= 3) && (n <= 2 * DEPTH + 1) && (n % 2 == 1);
        if (rd_en_o !== exp_rd) rd_bad++;
        if (rd_en_o === 1'b1) begin
          if (addr_o !== IDX_W'(pulses)) addr_bad++;
          pulses++;
        end
      end
      if (poke_go) go_i = (n >= 100 && n <= 103);
      if (n == LAST_EDGE - 1)
        check(longint'(sad_o) == old_sad, "R5", {name, " sad before completion"},
              longint'(sad_o), old_sad);
    end
    go_i = 1'b0;
    check(rd_bad == 0 && pulses == DEPTH, poke_go ? "R7" : "R2",
          {name, " read-enable pattern errors"}, rd_bad, 0);
    check(addr_bad == 0, "R3", {name, " address sequence errors"}, addr_bad, 0);
    check(addr_o == IDX_W'(DEPTH), "R8", {name, " final index"}, longint'(addr_o), DEPTH);
    check(longint'(sad_o) == exp_sad, poke_go ? "R7" : "R4", {name, " result"},
          longint'(sad_o), exp_sad);
    repeat (7) @(negedge clk_i);
    check(longint'(sad_o) == exp_sad && rd_en_o == 1'b0, "R6", {name, " idle hold"},
          longint'(sad_o), exp_sad);
  endtask

  initial begin
    void'($urandom(32'd2741));
    repeat (3) @(negedge clk_i);
    check(sad_o == '0 && rd_en_o == 1'b0, "R1", "sad during reset", longint'(sad_o), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check(sad_o == '0 && rd_en_o == 1'b0, "R1", "sad after reset", longint'(sad_o), 0);
    fill(1); run("equal", 1'b0);
    fill(2); run("a_max", 1'b0);
    fill(1); run("equal_after_max", 1'b0);
    fill(3); run("b_max", 1'b0);
    fill(0); run("random0", 1'b0);
    fill(0); run("random1", 1'b0);
    fill(0); run("random_go_poke", 1'b1);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule